// File: doc/BRIEF.md
# Dual-Bank ISA Interrupt Mask Unit

This unit gathers sixteen ISA-style interrupt request lines and presents a single interrupt request to the processor. The lines are split into two eight-line banks: lines 0-7 form the low bank and lines 8-15 form the high bank. Each bank has a two-byte register window. Its odd byte holds an active-low mask for that bank's eight lines. A write to its even byte discards every pending request of that bank at once.

Each input line is sampled on every clock. A rising edge makes the line pending and a falling edge withdraws it. The processor request is raised while at least one line is both pending and enabled. A separate vector register gives the lowest-numbered line that is pending and enabled. Software reads it to choose which handler to run.

Register accesses are single-cycle strobes on `acc_en`. Read data appears on `acc_rdata` in the cycle after the read strobe and holds until the next read.

Top module: `isa_irq_mask_unit`

## Requirements
- R1: After reset the enable mask is 0xFFFF, no line is pending, `cpu_irq` is low and `acc_rdata` is zero.
- R2: A line sampled high when it was low on the previous clock becomes pending. A line sampled low when it was high on the previous clock stops being pending.
- R3: `cpu_irq` is high exactly while some line is both pending and enabled, judged from the registered state after each clock.
- R4: A write to address 1 stores the bitwise inverse of `acc_wdata` into enable bits 7:0 and leaves bits 15:8 unchanged.
- R5: A write to address 3 stores the bitwise inverse of `acc_wdata` into enable bits 15:8 and leaves bits 7:0 unchanged.
- R6: A read of address 1 or address 3 returns the whole 16-bit enable mask on `acc_rdata` one cycle later.
- R7: A write to address 0 clears pending bits 7:0, and a write to address 2 clears pending bits 15:8. The data value is ignored and the other bank is untouched. A line that stays high after being cleared does not become pending again until it falls and rises.
- R8: If a line rises in the same cycle as a clear write to its bank, the line ends up pending.
- R9: A read of address 4 returns the index (0-15) of the lowest line that is both pending and enabled, or 0 when there is none.
- R10: Reads of address 0, address 2 and addresses 5-7 return 0. Writes to address 4 and addresses 5-7 change no state.
- R11: A pending line whose enable bit is clear stays pending without raising `cpu_irq`, and raises it once its enable bit is set again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 16 | Interrupt request lines, bit n is line n |
| acc_en | input | 1 | Register access strobe, one cycle per access |
| acc_wr | input | 1 | 1 for a write, 0 for a read |
| acc_addr | input | 3 | Register address: 0/1 low bank, 2/3 high bank, 4 vector |
| acc_wdata | input | 8 | Write data byte |
| acc_rdata | output | 16 | Read data, valid the cycle after a read strobe |
| cpu_irq | output | 1 | Combined interrupt request to the processor |

## Verification
The bench sets one mask bank to all-off and then writes the other bank. A design that does not invert the byte, or that writes the wrong byte, would leave the wrong lines masked and give a wrong vector. It holds a line high through a bank clear. A design that treats pending as a plain level would raise the request again at once. It also clears a bank in the same cycle a new line in that bank rises. If the clear wins there, the request drops and the vector reads 0 instead of that line. Lines are kept pending in both banks while one bank is cleared, and lines 0 and 15 are active together. Priority or bank-select mistakes therefore show up as a wrong vector index.

// File: rtl/isa_irq_pkg.sv
package isa_irq_pkg;

    // Decoded meaning of the current register access
    typedef enum logic [2:0] {
        KIND_NONE     = 3'd0,
        KIND_CLEAR_WR = 3'd1,
        KIND_MASK_WR  = 3'd2,
        KIND_MASK_RD  = 3'd3,
        KIND_VEC_RD   = 3'd4,
        KIND_ZERO_RD  = 3'd5
    } acc_kind_e;

endpackage

// File: rtl/isa_irq_decode.sv
module isa_irq_decode
    import isa_irq_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int ADDR_W    = 3,
    parameter int BSEL_W    = 1
) (
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    output acc_kind_e         kind,
    output logic [BSEL_W-1:0] bank_sel
);
    // Bank windows occupy two bytes each; the vector register follows them
    localparam int VEC_ADDR = 2 * NUM_BANKS;

    always_comb begin
        kind     = KIND_NONE;
        bank_sel = BSEL_W'(acc_addr >> 1);
        if (acc_en) begin
            if (acc_addr < ADDR_W'(VEC_ADDR)) begin
                if (acc_addr[0]) begin
                    kind = acc_wr ? KIND_MASK_WR : KIND_MASK_RD;
                end else begin
                    kind = acc_wr ? KIND_CLEAR_WR : KIND_ZERO_RD;
                end
            end else if (acc_addr == ADDR_W'(VEC_ADDR)) begin
                kind = acc_wr ? KIND_NONE : KIND_VEC_RD;
            end else begin
                kind = acc_wr ? KIND_NONE : KIND_ZERO_RD;
            end
        end
    end
endmodule

// File: rtl/isa_irq_bank.sv
module isa_irq_bank #(
    parameter int BANK_W = 8
) (
    input  logic [BANK_W-1:0] line_now,
    input  logic [BANK_W-1:0] line_prev,
    input  logic [BANK_W-1:0] pend_cur,
    input  logic [BANK_W-1:0] en_cur,
    input  logic              clr_hit,
    input  logic              mask_hit,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] pend_nxt,
    output logic [BANK_W-1:0] en_nxt
);
    logic [BANK_W-1:0] rise;
    logic [BANK_W-1:0] fall;
    logic [BANK_W-1:0] kept;

    always_comb begin
        rise = line_now & ~line_prev;
        fall = ~line_now & line_prev;
        // Bank clear and falling edges drop bits; a new edge always wins
        kept     = clr_hit ? '0 : pend_cur;
        pend_nxt = (kept & ~fall) | rise;
        // Mask is written active-low
        en_nxt   = mask_hit ? ~wdata : en_cur;
    end
endmodule

// File: rtl/isa_irq_lowest.sv
module isa_irq_lowest #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     req,
    output logic [IDX_W-1:0] idx,
    output logic             found
);
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx   = IDX_W'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/isa_irq_mask_unit.sv
module isa_irq_mask_unit
    import isa_irq_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int BANK_W    = 8,
    localparam int NUM_BANKS = NUM_LINES / BANK_W,
    localparam int ADDR_W    = $clog2(2 * NUM_BANKS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_lines,
    input  logic                 acc_en,
    input  logic                 acc_wr,
    input  logic [ADDR_W-1:0]    acc_addr,
    input  logic [BANK_W-1:0]    acc_wdata,
    output logic [NUM_LINES-1:0] acc_rdata,
    output logic                 cpu_irq
);
    localparam int BSEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
    localparam int VEC_W  = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    typedef struct packed {
        logic [NUM_LINES-1:0] lines;
        logic [NUM_LINES-1:0] pend;
        logic [NUM_LINES-1:0] en;
        logic [NUM_LINES-1:0] rdata;
    } state_t;

    state_t state_d;
    state_t state_q;

    acc_kind_e            kind;
    logic [BSEL_W-1:0]    bank_sel;
    logic [NUM_LINES-1:0] pend_next;
    logic [NUM_LINES-1:0] en_next;
    logic [NUM_LINES-1:0] active;
    logic [VEC_W-1:0]     vec_idx;
    logic                 vec_found;

    isa_irq_decode #(
        .NUM_BANKS (NUM_BANKS),
        .ADDR_W    (ADDR_W),
        .BSEL_W    (BSEL_W)
    ) u_decode (
        .acc_en   (acc_en),
        .acc_wr   (acc_wr),
        .acc_addr (acc_addr),
        .kind     (kind),
        .bank_sel (bank_sel)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic clr_hit;
        logic mask_hit;
        assign clr_hit  = (kind == KIND_CLEAR_WR) && (bank_sel == BSEL_W'(b));
        assign mask_hit = (kind == KIND_MASK_WR)  && (bank_sel == BSEL_W'(b));

        isa_irq_bank #(
            .BANK_W (BANK_W)
        ) u_bank (
            .line_now  (irq_lines[b*BANK_W +: BANK_W]),
            .line_prev (state_q.lines[b*BANK_W +: BANK_W]),
            .pend_cur  (state_q.pend[b*BANK_W +: BANK_W]),
            .en_cur    (state_q.en[b*BANK_W +: BANK_W]),
            .clr_hit   (clr_hit),
            .mask_hit  (mask_hit),
            .wdata     (acc_wdata),
            .pend_nxt  (pend_next[b*BANK_W +: BANK_W]),
            .en_nxt    (en_next[b*BANK_W +: BANK_W])
        );
    end

    assign active = state_q.pend & state_q.en;

    isa_irq_lowest #(
        .N     (NUM_LINES),
        .IDX_W (VEC_W)
    ) u_lowest (
        .req   (active),
        .idx   (vec_idx),
        .found (vec_found)
    );

    always_comb begin
        state_d       = state_q;
        state_d.lines = irq_lines;
        state_d.pend  = pend_next;
        state_d.en    = en_next;
        case (kind)
            KIND_MASK_RD: state_d.rdata = state_q.en;
            KIND_VEC_RD:  state_d.rdata = vec_found ? NUM_LINES'(vec_idx) : '0;
            KIND_ZERO_RD: state_d.rdata = '0;
            default:      state_d.rdata = state_q.rdata;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.lines <= '0;
            state_q.pend  <= '0;
            state_q.en    <= '1;
            state_q.rdata <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign acc_rdata = state_q.rdata;
    assign cpu_irq   = |active;
endmodule

// File: rtl/isa_irq_mask_chk.sv
module isa_irq_mask_chk #(
    parameter int NUM_LINES = 16,
    parameter int BANK_W    = 8,
    parameter int ADDR_W    = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINES-1:0] irq_lines,
    input logic                 acc_en,
    input logic                 acc_wr,
    input logic [ADDR_W-1:0]    acc_addr,
    input logic [BANK_W-1:0]    acc_wdata,
    input logic [NUM_LINES-1:0] acc_rdata,
    input logic                 cpu_irq,
    input logic [NUM_LINES-1:0] pend_q,
    input logic [NUM_LINES-1:0] lines_q,
    input logic [NUM_LINES-1:0] en_q
);
    localparam int NUM_BANKS = NUM_LINES / BANK_W;
    localparam int VEC_ADDR  = 2 * NUM_BANKS;

    logic              mask_wr;
    logic              ign_wr;
    logic              vec_rd;
    logic              seen_q;
    logic [ADDR_W-1:0] bank_q;
    logic [BANK_W-1:0] data_q;

    assign mask_wr = acc_en && acc_wr && (acc_addr < ADDR_W'(VEC_ADDR)) && acc_addr[0];
    assign ign_wr  = acc_en && acc_wr && (acc_addr >= ADDR_W'(VEC_ADDR));
    assign vec_rd  = acc_en && !acc_wr && (acc_addr == ADDR_W'(VEC_ADDR));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            bank_q <= '0;
            data_q <= '0;
        end else begin
            seen_q <= mask_wr;
            bank_q <= acc_addr >> 1;
            data_q <= acc_wdata;
        end
    end

    // R2
    rise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(irq_lines & ~lines_q & en_q)) && !mask_wr) |=> cpu_irq);

    // R2
    all_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lines == '0) |=> !cpu_irq);

    // R7
    pend_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q & ~lines_q) == '0);

    // R4
    mask_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (BANK_W'(en_q >> (int'(bank_q) * BANK_W)) == ~data_q));

    // R9
    vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && !cpu_irq) |=> (acc_rdata == '0));

    // R10
    ign_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ign_wr |=> (en_q == $past(en_q)));
endmodule

bind isa_irq_mask_unit isa_irq_mask_chk #(
    .NUM_LINES (NUM_LINES),
    .BANK_W    (BANK_W),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_lines (irq_lines),
    .acc_en    (acc_en),
    .acc_wr    (acc_wr),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata),
    .acc_rdata (acc_rdata),
    .cpu_irq   (cpu_irq),
    .pend_q    (state_q.pend),
    .lines_q   (state_q.lines),
    .en_q      (state_q.en)
);

// File: tb/isa_irq_mask_unit_tb_top.sv
`timescale 1ns/1ps
module isa_irq_mask_unit_tb_top;
    localparam int NL = 16;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] irq_lines = '0;
    logic          acc_en = 1'b0;
    logic          acc_wr = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic [7:0]    acc_wdata = '0;
    logic [NL-1:0] acc_rdata;
    logic          cpu_irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    isa_irq_mask_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_lines (irq_lines),
        .acc_en    (acc_en),
        .acc_wr    (acc_wr),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .acc_rdata (acc_rdata),
        .cpu_irq   (cpu_irq)
    );

    typedef struct packed {
        logic [15:0] lines;
        logic        wr;
        logic [2:0]  addr;
        logic [7:0]  wdata;
        logic        exp_irq;
        logic [3:0]  exp_vec;
    } step_t;

    // lines, write?, addr, data, expected request, expected vector
    localparam step_t STEPS [12] = '{
        '{16'h0000, 1'b0, 3'd0, 8'h00, 1'b0, 4'd0},
        '{16'h0020, 1'b0, 3'd0, 8'h00, 1'b1, 4'd5},
        '{16'h0820, 1'b0, 3'd0, 8'h00, 1'b1, 4'd5},
        '{16'h0820, 1'b1, 3'd1, 8'h20, 1'b1, 4'd11},
        '{16'h0820, 1'b1, 3'd3, 8'h08, 1'b0, 4'd0},
        '{16'h0820, 1'b1, 3'd1, 8'h00, 1'b1, 4'd5},
        '{16'h0800, 1'b0, 3'd0, 8'h00, 1'b0, 4'd0},
        '{16'h0800, 1'b1, 3'd3, 8'h00, 1'b1, 4'd11},
        '{16'h0800, 1'b1, 3'd2, 8'h00, 1'b0, 4'd0},
        '{16'h8801, 1'b0, 3'd0, 8'h00, 1'b1, 4'd0},
        '{16'h8801, 1'b1, 3'd0, 8'h00, 1'b1, 4'd15},
        '{16'h0000, 1'b0, 3'd0, 8'h00, 1'b0, 4'd0}
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [15:0] l);
        @(negedge clk);
        irq_lines = l;
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = 1'b1; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_en = 1'b0; acc_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = 1'b0; acc_addr = a;
        @(negedge clk);
        acc_en = 1'b0;
        v = acc_rdata;
    endtask

    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 cpu_irq after reset", {15'd0, cpu_irq}, 16'h0000);
        check("R1 rdata after reset", acc_rdata, 16'h0000);
        rd(3'd1, v); check("R1 mask after reset", v, 16'hFFFF);
        rd(3'd3, v); check("R6 mask via high window", v, 16'hFFFF);

        // Table walk: R2 R3 R4 R5 R7 R9
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            irq_lines = STEPS[i].lines;
            if (STEPS[i].wr) begin
                acc_en = 1'b1; acc_wr = 1'b1;
                acc_addr = STEPS[i].addr; acc_wdata = STEPS[i].wdata;
            end
            @(negedge clk);
            acc_en = 1'b0; acc_wr = 1'b0;
            check($sformatf("R3 step %0d request", i), {15'd0, cpu_irq}, {15'd0, STEPS[i].exp_irq});
            rd(3'd4, v);
            check($sformatf("R9 step %0d vector", i), v, {12'd0, STEPS[i].exp_vec});
        end

        // R4 / R5 / R6: byte lanes, inversion
        wr(3'd1, 8'h5A);
        rd(3'd3, v); check("R4 low lane inverted", v, 16'hFFA5);
        wr(3'd3, 8'h0F);
        rd(3'd1, v); check("R5 high lane inverted", v, 16'hF0A5);
        wr(3'd1, 8'h00); wr(3'd3, 8'h00);
        rd(3'd1, v); check("R6 mask restored", v, 16'hFFFF);

        // R11: masked pending line
        wr(3'd1, 8'h04);
        drive(16'h0004);
        check("R11 masked line quiet", {15'd0, cpu_irq}, 16'h0000);
        wr(3'd1, 8'h00);
        check("R11 unmask raises request", {15'd0, cpu_irq}, 16'h0001);
        rd(3'd4, v); check("R11 vector after unmask", v, 16'd2);

        // R7: bank clear, other bank kept, held line stays cleared
        drive(16'h0404);
        wr(3'd0, 8'hFF);
        rd(3'd4, v); check("R7 high bank kept", v, 16'd10);
        wr(3'd2, 8'h00);
        repeat (3) @(negedge clk);
        check("R7 held lines stay cleared", {15'd0, cpu_irq}, 16'h0000);
        drive(16'h0400);
        drive(16'h0404);
        rd(3'd4, v); check("R7 re-rise pends again", v, 16'd2);

        // R8: rise beats clear in the same cycle
        drive(16'h0000);
        drive(16'h0008);
        @(negedge clk);
        irq_lines = 16'h0018;
        acc_en = 1'b1; acc_wr = 1'b1; acc_addr = 3'd0; acc_wdata = 8'h00;
        @(negedge clk);
        acc_en = 1'b0; acc_wr = 1'b0;
        check("R8 request kept", {15'd0, cpu_irq}, 16'h0001);
        rd(3'd4, v); check("R8 rising line wins", v, 16'd4);

        // R10: zero reads, ignored writes
        rd(3'd0, v); check("R10 read addr0", v, 16'h0000);
        rd(3'd2, v); check("R10 read addr2", v, 16'h0000);
        rd(3'd6, v); check("R10 read addr6", v, 16'h0000);
        wr(3'd5, 8'hFF); wr(3'd7, 8'hFF); wr(3'd4, 8'hFF);
        rd(3'd1, v); check("R10 mask unchanged", v, 16'hFFFF);
        check("R10 request unchanged", {15'd0, cpu_irq}, 16'h0001);
        rd(3'd4, v); check("R10 pending unchanged", v, 16'd4);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule